// File: doc/BRIEF.md
# Lane Address Coalescer

This block takes one memory request from a group of sixteen parallel lanes and turns the per-lane addresses into as few aligned memory transactions as it can. Each lane supplies an address and an active flag. The request also carries an element-size code and a mode bit. The block then emits a series of transactions over a valid/ready handshake. Each transaction carries an aligned base address, a size code and a mask of the lanes it serves.

In the default, relaxed mode the block works in rounds. Each round is seeded by the lowest-numbered lane that still waits for service. The round gathers every waiting lane whose address falls in the seed's aligned segment. The transaction is then shrunk to the smallest aligned block that still covers the bytes of those lanes. The strict mode models an older scheme: lane k must address the k-th element of one segment. If the request follows that rule, it coalesces as usual. If not, every active lane gets its own minimum-size transaction.

The block asserts `done` for one cycle once the last transaction of a request has been accepted. Data return, storage and caching are handled elsewhere.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0 and `done` is 0.
- R2: Each transaction's mask contains the lowest-numbered lane still waiting for service, so transactions appear in ascending order of their lowest lane.
- R3: The segment size follows `req_esize`: code 0 (1-byte elements) gives 32 bytes, code 1 (2-byte) gives 64 bytes, and codes 2 and 3 (4-byte and 8-byte) give 128 bytes.
- R4: Every waiting lane whose address lies in the same aligned segment as the seed lane joins the seed's transaction.
- R5: `txn_size` is 0 for 32 bytes, 1 for 64 and 2 for 128. A 128-byte segment whose used bytes all lie in one aligned 64-byte half becomes a 64-byte transaction. A 64-byte one whose used bytes lie in one aligned 32-byte half becomes 32 bytes. `txn_base` is aligned to the final size.
- R6: Inactive lanes never appear in any mask, and their addresses do not change the transactions.
- R7: Every active lane is served exactly once. `done` is high for exactly the one cycle after the last transaction is accepted, and then `req_ready` returns to 1.
- R8: A request with no active lanes issues no transaction, and `done` is high in the cycle after the request is accepted.
- R9: In strict mode, the rule is that every active lane k addresses the segment base of the lowest active lane plus k times the element size. A request that meets this rule gives the same transactions as relaxed mode.
- R10: In strict mode, a request that breaks the rule for any active lane gives one 32-byte transaction per active lane, in ascending lane order, each with a one-lane mask.
- R11: While `txn_valid` is high and `txn_ready` is low, `txn_base`, `txn_size` and `txn_mask` hold steady. A request is accepted only when `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*ADDR_W | Lane k address in bits [k*ADDR_W +: ADDR_W] |
| req_active | input | LANES | Per-lane active flags |
| req_esize | input | 2 | Element size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_strict | input | 1 | 1 selects the strict in-order scheme |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted when high with `txn_valid` |
| txn_base | output | ADDR_W | Aligned base address of the transaction |
| txn_size | output | 2 | Size code: 0=32B, 1=64B, 2=128B |
| txn_mask | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse when a request is fully served |

## Verification
The assertions rely on three things about the inputs. Each lane address is aligned to its element size, so no element straddles a half-segment boundary. Addresses stay below the top of the address space. `txn_ready` may stall freely. The stimulus keeps within these limits in two ways. Every generated address is masked to element alignment with the top bit cleared. Random stalls are applied on the transaction side while requests are spread over sequential, windowed, narrow and fully scattered address patterns with random activity masks.

// File: rtl/coal_pkg.sv
// Shared types for the lane address coalescer.
// Assumes size codes are ordered so that a smaller code means a smaller block.
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } coal_state_e;

    // Transaction size codes: 0=32B, 1=64B, 2=128B
    localparam logic [1:0] SZ_32  = 2'd0;
    localparam logic [1:0] SZ_64  = 2'd1;
    localparam logic [1:0] SZ_128 = 2'd2;

    // Segment size code for an element size code (1B->32, 2B->64, 4B/8B->128)
    function automatic logic [1:0] seg_code_of(input logic [1:0] esize);
        case (esize)
            2'd0:    return SZ_32;
            2'd1:    return SZ_64;
            default: return SZ_128;
        endcase
    endfunction

endpackage

// File: rtl/coal_lane_match.sv
// Finds the lowest pending lane (the seed) and marks every pending lane
// whose address lies in the seed's aligned segment.
// Assumes seg_code is 0..2; purely combinational.
module coal_lane_match #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        pending,
    input  logic [1:0]              seg_code,
    output logic                    any_pend,
    output logic [IDX_W-1:0]        seed_idx,
    output logic [ADDR_W-1:0]       seed_addr,
    output logic [LANES-1:0]        member
);

    logic [ADDR_W-1:0] lane_a [LANES];
    logic [ADDR_W-1:0] low_m;

    // Unpack lane addresses
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_a[g] = addr_flat[g*ADDR_W +: ADDR_W];
    end

    // Priority pick of the lowest pending lane
    always_comb begin
        seed_idx = '0;
        any_pend = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                seed_idx = IDX_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    assign seed_addr = lane_a[seed_idx];

    // Offset bits inside one segment
    always_comb begin
        case (seg_code)
            2'd0:    low_m = ADDR_W'(7'h1F);
            2'd1:    low_m = ADDR_W'(7'h3F);
            default: low_m = ADDR_W'(7'h7F);
        endcase
    end

    // Per-lane segment match against the seed
    for (genvar g = 0; g < LANES; g++) begin : g_match
        assign member[g] = pending[g] && (((lane_a[g] ^ seed_addr) & ~low_m) == '0);
    end

endmodule

// File: rtl/coal_size_reduce.sv
// Shrinks a segment to the smallest aligned block that covers its member lanes
// and realigns the base address. Bits 6 and 5 of each lane address are given.
// Assumes lane addresses are aligned to the element size, so an element never
// crosses a 32-byte boundary.
module coal_size_reduce #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        seg_code,
    input  logic [LANES-1:0]  member,
    input  logic [LANES-1:0]  lane_b6,
    input  logic [LANES-1:0]  lane_b5,
    input  logic [ADDR_W-1:0] seed_addr,
    output logic [1:0]        size_code,
    output logic [ADDR_W-1:0] base
);

    logic same_half64;
    logic same_half32;
    logic [ADDR_W-1:0] low_m;

    // Do all members agree on which 64-byte and 32-byte half they use?
    assign same_half64 = !((|(member & lane_b6)) && (|(member & ~lane_b6)));
    assign same_half32 = !((|(member & lane_b5)) && (|(member & ~lane_b5)));

    // Two-step reduction 128 -> 64 -> 32
    always_comb begin
        size_code = seg_code;
        if (size_code == 2'd2 && same_half64) size_code = 2'd1;
        if (size_code == 2'd1 && same_half32) size_code = 2'd0;
    end

    // Realign the base to the final size
    always_comb begin
        case (size_code)
            2'd0:    low_m = ADDR_W'(7'h1F);
            2'd1:    low_m = ADDR_W'(7'h3F);
            default: low_m = ADDR_W'(7'h7F);
        endcase
        base = seed_addr & ~low_m;
    end

endmodule

// File: rtl/coal_order_check.sv
// Decides whether a request follows the strict in-order rule: every active
// lane k addresses the segment base of the lowest active lane plus k elements.
// A request with no active lanes counts as in order. Combinational.
module coal_order_check #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        active,
    input  logic [1:0]              esize,
    output logic                    in_order
);

    logic [ADDR_W-1:0] first_a;
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] low_m;
    logic [LANES-1:0]  lane_ok;

    // Address of the lowest active lane
    always_comb begin
        first_a = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (active[i]) first_a = addr_flat[i*ADDR_W +: ADDR_W];
        end
    end

    // Segment base of that lane
    always_comb begin
        case (coal_pkg::seg_code_of(esize))
            2'd0:    low_m = ADDR_W'(7'h1F);
            2'd1:    low_m = ADDR_W'(7'h3F);
            default: low_m = ADDR_W'(7'h7F);
        endcase
        seg_base = first_a & ~low_m;
    end

    // Per-lane in-order test
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = !active[g] ||
            (addr_flat[g*ADDR_W +: ADDR_W] == seg_base + (ADDR_W'(g) << esize));
    end

    assign in_order = &lane_ok;

endmodule

// File: rtl/mem_coalescer.sv
// Lane address coalescer top. Takes one request and issues aligned
// transactions round by round until every active lane is served, then
// pulses done. Assumes element-aligned lane addresses.
module mem_coalescer #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_active,
    input  logic [1:0]              req_esize,
    input  logic                    req_strict,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [1:0]              txn_size,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done
);
    import coal_pkg::*;

    coal_state_e             state_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        act_q;
    logic [LANES-1:0]        pend_q;
    logic [1:0]              seg_q;
    logic                    split_q;

    logic                    in_order;
    logic                    any_pend;
    logic [IDX_W-1:0]        seed_idx;
    logic [ADDR_W-1:0]       seed_addr;
    logic [LANES-1:0]        member;
    logic [LANES-1:0]        lane_b6;
    logic [LANES-1:0]        lane_b5;
    logic [1:0]              red_size;
    logic [ADDR_W-1:0]       red_base;
    logic [LANES-1:0]        pend_next;

    // Strict-rule test on the incoming request
    coal_order_check #(.LANES(LANES), .ADDR_W(ADDR_W)) i_order (
        .addr_flat (req_addr),
        .active    (req_active),
        .esize     (req_esize),
        .in_order  (in_order)
    );

    // Seed selection and segment membership over pending lanes
    coal_lane_match #(.LANES(LANES), .ADDR_W(ADDR_W)) i_match (
        .addr_flat (addr_q),
        .pending   (pend_q),
        .seg_code  (seg_q),
        .any_pend  (any_pend),
        .seed_idx  (seed_idx),
        .seed_addr (seed_addr),
        .member    (member)
    );

    // Address bits that decide half-segment placement
    for (genvar g = 0; g < LANES; g++) begin : g_bits
        assign lane_b6[g] = addr_q[g*ADDR_W + 6];
        assign lane_b5[g] = addr_q[g*ADDR_W + 5];
    end

    // Size reduction of the coalesced segment
    coal_size_reduce #(.LANES(LANES), .ADDR_W(ADDR_W)) i_reduce (
        .seg_code  (seg_q),
        .member    (member),
        .lane_b6   (lane_b6),
        .lane_b5   (lane_b5),
        .seed_addr (seed_addr),
        .size_code (red_size),
        .base      (red_base)
    );

    // Transaction fields: per-lane minimum blocks when split, else coalesced
    always_comb begin
        if (split_q) begin
            txn_mask = '0;
            txn_mask[seed_idx] = 1'b1;
            txn_size = SZ_32;
            txn_base = seed_addr & ~ADDR_W'(7'h1F);
        end else begin
            txn_mask = member;
            txn_size = red_size;
            txn_base = red_base;
        end
    end

    assign pend_next = pend_q & ~txn_mask;
    assign req_ready = (state_q == ST_IDLE);
    assign txn_valid = (state_q == ST_BUSY);
    assign done      = (state_q == ST_DONE);

    // Request capture, round retirement and completion sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            act_q   <= '0;
            pend_q  <= '0;
            seg_q   <= SZ_32;
            split_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        act_q   <= req_active;
                        pend_q  <= req_active;
                        seg_q   <= seg_code_of(req_esize);
                        split_q <= req_strict && !in_order;
                        state_q <= (|req_active) ? ST_BUSY : ST_DONE;
                    end
                end
                ST_BUSY: begin
                    if (txn_ready) begin
                        pend_q <= pend_next;
                        if (pend_next == '0) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> any_pend);                                            // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));                                     // R7
    AST_MASK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0 && (txn_mask & ~act_q) == '0));       // R6
    AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_size == 2'd0 && txn_base[4:0] == '0) ||
                       (txn_size == 2'd1 && txn_base[5:0] == '0) ||
                       (txn_size == 2'd2 && txn_base[6:0] == '0)));         // R5
    AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) &&
                                       $stable(txn_size) && $stable(txn_mask))); // R11
    AST_SPLIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && split_q) |-> ($countones(txn_mask) == 1 && txn_size == 2'd0)); // R10

endmodule

// File: tb/test_mem_coalescer.sv
`timescale 1ns/1ps
module test_mem_coalescer;
    localparam int LANES  = 16;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_active = '0;
    logic [1:0]              req_esize = '0;
    logic                    req_strict = 1'b0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_base;
    logic [1:0]              txn_size;
    logic [LANES-1:0]        txn_mask;
    logic                    done;

    int checks = 0;
    int errors = 0;

    logic [31:0] la [LANES];
    logic [15:0] act;
    int          esz;
    bit          strict;

    logic [31:0] eb [LANES];
    logic [1:0]  es [LANES];
    logic [15:0] em [LANES];
    int          ne;

    always #2.5 clk = ~clk;

    mem_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) i_mem_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .req_esize(req_esize),
        .req_strict(req_strict), .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_size(txn_size), .txn_mask(txn_mask), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act_v,
                         input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    // Strict rule: lane k at segment base of lowest active lane + k elements (R9)
    function automatic bit ordered();
        int eb_n = 1 << esz;
        int seg = (esz == 0) ? 32 : (esz == 1) ? 64 : 128;
        logic [31:0] sb = 0;
        bit found = 0;
        for (int k = 0; k < LANES; k++)
            if (act[k] && !found) begin sb = la[k] & ~32'(seg - 1); found = 1; end
        for (int k = 0; k < LANES; k++)
            if (act[k] && la[k] != sb + 32'(k * eb_n)) return 0;
        return 1;
    endfunction

    // Expected transaction list from the requirements (R2..R6, R9, R10)
    task automatic build_model();
        int eb_n = 1 << esz;
        int seg = (esz == 0) ? 32 : (esz == 1) ? 64 : 128;
        logic [15:0] pend = act;
        ne = 0;
        if (strict && !ordered()) begin
            for (int k = 0; k < LANES; k++)
                if (act[k]) begin
                    eb[ne] = la[k] & ~32'h1F; es[ne] = 2'd0; em[ne] = 16'(1 << k); ne++;
                end
        end else begin
            while (pend != 0) begin
                int sd = 0;
                logic [31:0] sb, mn, mx;
                logic [15:0] mem;
                int sz;
                for (int k = LANES - 1; k >= 0; k--) if (pend[k]) sd = k;
                sb = la[sd] & ~32'(seg - 1);
                mn = la[sd]; mx = la[sd] + 32'(eb_n - 1); mem = 0;
                for (int k = 0; k < LANES; k++)
                    if (pend[k] && (la[k] & ~32'(seg - 1)) == sb) begin
                        mem[k] = 1'b1;
                        if (la[k] < mn) mn = la[k];
                        if (la[k] + 32'(eb_n - 1) > mx) mx = la[k] + 32'(eb_n - 1);
                    end
                sz = seg;
                while (sz > 32 && (mn / 32'(sz / 2)) == (mx / 32'(sz / 2))) sz = sz / 2;
                eb[ne] = mn & ~32'(sz - 1);
                es[ne] = (sz == 32) ? 2'd0 : (sz == 64) ? 2'd1 : 2'd2;
                em[ne] = mem;
                ne++;
                pend = pend & ~mem;
            end
        end
    endtask

    // Drive one request and compare every transaction and the done pulse
    task automatic run_req(input string tag, input bit stalls);
        int seen = 0;
        bit last_acc = 1;
        bit got_done = 0;
        build_model();
        @(negedge clk);
        for (int k = 0; k < LANES; k++) req_addr[k*ADDR_W +: ADDR_W] = la[k];
        req_active = act; req_esize = 2'(esz); req_strict = strict;
        req_valid = 1'b1;
        check(req_ready == 1'b1, {tag, " R11 req_ready before request"}, 32'(req_ready), 1);
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
            @(negedge clk);
            txn_ready = 1'b0;
            if (done) begin
                got_done = 1;
                check(seen == ne, {tag, " R7 transaction count at done"}, 32'(seen), 32'(ne));
                check(last_acc, {tag, ne == 0 ? " R8 done timing" : " R7 done timing"},
                      32'(last_acc), 1);
            end else if (txn_valid) begin
                bit rdy = stalls ? ($urandom % 3 != 0) : 1'b1;
                if (seen >= ne) begin
                    check(0, {tag, " R7 extra transaction"}, 32'(seen), 32'(ne));
                end else if (rdy) begin
                    check(txn_mask == em[seen], {tag, " R2/R4/R6/R10 mask"}, 32'(txn_mask), 32'(em[seen]));
                    check(txn_base == eb[seen], {tag, " R5 base"}, txn_base, eb[seen]);
                    check(txn_size == es[seen], {tag, " R3/R5 size"}, 32'(txn_size), 32'(es[seen]));
                end
                txn_ready = rdy;
                last_acc = rdy;
                if (rdy) seen++;
            end else begin
                last_acc = 0;
            end
        end
        check(got_done, {tag, " R7 done seen"}, 32'(got_done), 1);
        @(negedge clk);
        txn_ready = 1'b0;
        check(!done && req_ready, {tag, " R7 single done pulse"}, {30'd0, done, req_ready}, 32'd1);
    endtask

    task automatic seq_lanes(input logic [31:0] base);
        for (int k = 0; k < LANES; k++) la[k] = base + 32'(k << esz);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1 && txn_valid == 0 && done == 0, "R1 reset outputs",
              {29'd0, req_ready, txn_valid, done}, 32'h4);
        rst_n = 1'b1;

        // Directed: R3/R5 sequential patterns per element size
        strict = 0; act = 16'hFFFF;
        esz = 2; seq_lanes(32'h0000_1000); run_req("4B seq R5", 0);
        esz = 0; seq_lanes(32'h0000_2000); run_req("1B seq R3", 0);
        esz = 3; seq_lanes(32'h0000_3000); run_req("8B seq R3", 1);
        esz = 1; seq_lanes(32'h0000_4040); run_req("2B seq upper half R5", 0);
        // R8: empty request
        act = 16'h0000; esz = 2; run_req("empty R8", 0);
        // R9: strict in order, some lanes inactive, garbage in inactive lanes (R6)
        strict = 1; esz = 2; act = 16'hA5F0; seq_lanes(32'h0000_5000);
        la[0] = 32'h0777_0000; la[2] = 32'h0123_4560;
        run_req("strict ordered R9", 1);
        // R10: strict with two lanes swapped
        act = 16'hFFFF; seq_lanes(32'h0000_6000);
        la[0] = 32'h0000_6004; la[1] = 32'h0000_6000;
        run_req("strict swapped R10", 1);
        // Same addresses relaxed: coalesces (R4)
        strict = 0; run_req("relaxed swapped R4", 0);
        // R2: every lane in its own segment
        for (int k = 0; k < LANES; k++) la[k] = 32'h0001_0000 + 32'(k * 256);
        run_req("scattered R2", 1);

        // Random requests
        for (int n = 0; n < 300; n++) begin
            int pat = $urandom % 4;
            logic [31:0] base = $urandom & 32'h7FFF_FF00;
            esz = $urandom % 4;
            strict = ($urandom % 3 == 0);
            case ($urandom % 4)
                0: act = 16'hFFFF;
                1: act = 16'($urandom) & 16'($urandom);
                default: act = 16'($urandom);
            endcase
            for (int k = 0; k < LANES; k++) begin
                logic [31:0] a;
                case (pat)
                    0: a = base + 32'(k << esz);
                    1: a = base + 32'($urandom % 256);
                    2: a = base + 32'($urandom % 64);
                    default: a = $urandom & 32'h7FFF_FFFF;
                endcase
                la[k] = a & ~32'((1 << esz) - 1);
            end
            if (pat == 0 && ($urandom % 2 == 1)) begin
                int j = $urandom % LANES;
                la[j] = la[j] ^ 32'h8;
            end
            run_req("random", 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule